// File: doc/BRIEF.md
# Serial-Load DAC Code Register

This block is the digital front end of a 12-bit voltage-output converter. A host shifts a code word in one bit at a time on a data pin. Each bit is taken on a rising edge of the serial clock, but only while the active-low select is held low. The shifted word stays in the serial register and does not reach the converter yet.

A separate active-low load strobe commits the word. On its falling edge, the serial register contents are copied into the parallel code register that drives the converter.

An active-low asynchronous clear forces the code register to zero, which is minimum scale. The clear is also the only model of power-on reset. The code register output sets the converter level directly at one millivolt per LSB. The analog ladder, reference and amplifier sit outside this block.

Top module: `dac_serial_front`

## Requirements
- R1: Bit `ser_data` is sampled into the serial register on each rising edge of `ser_clk` while `sel_n` is low.
- R2: Words are shifted most significant bit first: after 12 shifts, the first bit sent sits in bit 11 of the word later loaded.
- R3: A rising edge of `ser_clk` while `sel_n` is high leaves the serial register unchanged, whatever `ser_data` is.
- R4: A falling edge of `commit_n` while `wipe_n` is high copies the serial register into `code_out` at once, with no `ser_clk` edge needed.
- R5: While `wipe_n` is low, `code_out` is 0, and it becomes 0 asynchronously as soon as `wipe_n` falls.
- R6: When more than 12 bits are shifted before a commit, only the last 12 bits received are kept.
- R7: `code_out` holds its value through any amount of shifting until the next commit edge or clear.
- R8: `code_out` gives the output level in millivolts at 1 mV per LSB, so code 12'hFFF stands for 4095 mV and code 0 for 0 mV.
- R9: Clear wins over commit: a falling edge of `commit_n` while `wipe_n` is low leaves `code_out` at 0.
- R10: Neither commit nor clear alters the serial register. A word whose shifting is split by a clear pulse loads intact, and repeated commits reload the same word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| ser_clk | input | 1 | Serial shift clock, rising edge active |
| sel_n | input | 1 | Active-low select that enables shifting |
| ser_data | input | 1 | Serial data, MSB first |
| commit_n | input | 1 | Active-low asynchronous load strobe, falling edge commits |
| wipe_n | input | 1 | Active-low asynchronous clear of the code register |
| code_out | output | 12 | Committed converter code, 1 mV per LSB |

## Verification
The hardest state to reach from the ports is a clear that lands partway through a word. Only a later commit can show that the half-shifted serial contents survived the clear. The stimulus shifts six bits, pulses the clear with select high, finishes the remaining six bits, and then commits. It expects the whole word, and it expects zero during the clear.

Clear-over-commit priority is reached by dropping the load strobe while the clear is still held low. Select-gated clock edges are driven with the data pin toggling. Their effect is then made visible through a commit of the surrounding word.

// File: rtl/dac_front_pkg.sv
package dac_front_pkg;
    localparam int CODE_BITS   = 12;
    localparam int UV_PER_LSB  = 1000;
endpackage

// File: rtl/dac_shift_reg.sv
module dac_shift_reg #(
    parameter int WIDTH = dac_front_pkg::CODE_BITS
) (
    input  logic             ser_clk,
    input  logic             sel_n,
    input  logic             ser_data,
    output logic [WIDTH-1:0] word
);
    typedef struct packed {
        logic [WIDTH-1:0] bits;
    } shift_state_t;

    shift_state_t state_d, state_q;

    always_comb begin
        state_d = state_q;
        if (!sel_n) begin
            state_d.bits = {state_q.bits[WIDTH-2:0], ser_data};
        end
    end

    always_ff @(posedge ser_clk) begin
        state_q <= state_d;
    end

    assign word = state_q.bits;
endmodule

// File: rtl/dac_code_reg.sv
module dac_code_reg #(
    parameter int WIDTH = dac_front_pkg::CODE_BITS
) (
    input  logic             commit_n,
    input  logic             wipe_n,
    input  logic [WIDTH-1:0] word_in,
    output logic [WIDTH-1:0] code
);
    typedef struct packed {
        logic [WIDTH-1:0] value;
    } hold_state_t;

    hold_state_t hold_d, hold_q;

    always_comb begin
        hold_d       = hold_q;
        hold_d.value = word_in;
    end

    always_ff @(negedge commit_n or negedge wipe_n) begin
        if (!wipe_n) begin
            hold_q <= '0;
        end else begin
            hold_q <= hold_d;
        end
    end

    assign code = hold_q.value;
endmodule

// File: rtl/dac_serial_front.sv
module dac_serial_front #(
    parameter int WIDTH = dac_front_pkg::CODE_BITS
) (
    input  logic             ser_clk,
    input  logic             sel_n,
    input  logic             ser_data,
    input  logic             commit_n,
    input  logic             wipe_n,
    output logic [WIDTH-1:0] code_out
);
    logic [WIDTH-1:0] shift_word;

    dac_shift_reg #(.WIDTH(WIDTH)) u_shift (
        .ser_clk  (ser_clk),
        .sel_n    (sel_n),
        .ser_data (ser_data),
        .word     (shift_word)
    );

    dac_code_reg #(.WIDTH(WIDTH)) u_hold (
        .commit_n (commit_n),
        .wipe_n   (wipe_n),
        .word_in  (shift_word),
        .code     (code_out)
    );
endmodule

// File: rtl/dac_serial_front_chk.sv
module dac_serial_front_chk #(
    parameter int WIDTH = dac_front_pkg::CODE_BITS
) (
    input logic             ser_clk,
    input logic             sel_n,
    input logic             ser_data,
    input logic             commit_n,
    input logic             wipe_n,
    input logic [WIDTH-1:0] code_out,
    input logic [WIDTH-1:0] shift_word
);
    localparam int CW = $clog2(WIDTH + 1);
    logic [CW-1:0] seen_q;

    always_ff @(posedge ser_clk) begin
        if (!wipe_n) begin
            seen_q <= '0;
        end else if (!sel_n && seen_q < CW'(WIDTH)) begin
            seen_q <= seen_q + 1'b1;
        end
    end

    wire primed = (seen_q == CW'(WIDTH));

    assert_shift_in_R1: assert property (@(posedge ser_clk) disable iff (!wipe_n)
        (primed && !sel_n) |=> shift_word == {$past(shift_word[WIDTH-2:0]), $past(ser_data)});

    assert_idle_hold_R3: assert property (@(posedge ser_clk) disable iff (!wipe_n)
        (primed && sel_n) |=> $stable(shift_word));

    assert_clear_zero_R5: assert property (@(posedge ser_clk)
        !wipe_n |-> code_out == '0);

    assert_commit_copy_R4: assert property (@(posedge ser_clk) disable iff (!wipe_n)
        ($fell(commit_n) && sel_n && $past(sel_n) && $past(wipe_n)) |-> code_out == shift_word);

    assert_code_hold_R7: assert property (@(posedge ser_clk) disable iff (!wipe_n)
        (commit_n && $past(commit_n) && $past(wipe_n)) |-> $stable(code_out));
endmodule

bind dac_serial_front dac_serial_front_chk #(.WIDTH(WIDTH)) u_chk (
    .ser_clk    (ser_clk),
    .sel_n      (sel_n),
    .ser_data   (ser_data),
    .commit_n   (commit_n),
    .wipe_n     (wipe_n),
    .code_out   (code_out),
    .shift_word (shift_word)
);

// File: tb/dac_serial_front_test.sv
`timescale 1ns/1ps
module dac_serial_front_test;
    localparam int W = 12;

    logic ser_clk = 1'b0;
    logic sel_n = 1'b1, ser_data = 1'b0, commit_n = 1'b1, wipe_n = 1'b0;
    logic [W-1:0] code_out;
    int n_cmp = 0, n_bad = 0;
    bit done = 1'b0;

    dac_serial_front #(.WIDTH(W)) uut (
        .ser_clk(ser_clk), .sel_n(sel_n), .ser_data(ser_data),
        .commit_n(commit_n), .wipe_n(wipe_n), .code_out(code_out)
    );

    always #2.5 ser_clk = ~ser_clk;

    task automatic check(input string req, input logic [W-1:0] exp);
        n_cmp++;
        if (code_out !== exp) begin
            n_bad++;
            $display("FAIL %s: code_out=%h expected=%h", req, code_out, exp);
        end
    endtask

    task automatic shift_bits(input logic [31:0] v, input int n);
        for (int i = n - 1; i >= 0; i--) begin
            @(negedge ser_clk); sel_n = 1'b0; ser_data = v[i];
        end
        @(negedge ser_clk); sel_n = 1'b1;
    endtask

    task automatic commit;
        @(negedge ser_clk); #1 commit_n = 1'b0;
        @(negedge ser_clk); commit_n = 1'b1;
    endtask

    task automatic t_reset;
        repeat (3) @(negedge ser_clk);
        #1 check("R5 reset", '0);
        wipe_n = 1'b1;
    endtask

    task automatic t_basic;
        shift_bits(32'hA5C, 12);
        @(negedge ser_clk); #1 commit_n = 1'b0; #0.5;
        check("R4 immediate commit", 12'hA5C);
        @(negedge ser_clk); commit_n = 1'b1; #1;
        check("R1 R2 msb first", 12'hA5C);
        shift_bits(32'h801, 12); commit; #1 check("R2 msb position", 12'h801);
    endtask

    task automatic t_scale;
        shift_bits(32'hFFF, 12); commit; #1 check("R8 full scale 4095 mV", 12'd4095);
        shift_bits(32'h000, 12); commit; #1 check("R8 zero scale 0 mV", 12'd0);
    endtask

    task automatic t_overrun;
        shift_bits(32'hBEEF, 16); commit; #1 check("R6 last 12 bits", 12'hEEF);
    endtask

    task automatic t_gated;
        shift_bits(32'h0F, 6);
        for (int i = 0; i < 5; i++) begin
            @(negedge ser_clk); sel_n = 1'b1; ser_data = i[0];
        end
        shift_bits(32'h03, 6); commit; #1 check("R3 gated edges ignored", 12'h3C3);
    endtask

    task automatic t_hold;
        shift_bits(32'h5A5, 12); #1 check("R7 hold during shift", 12'h3C3);
        repeat (4) @(negedge ser_clk); #1 check("R7 hold idle", 12'h3C3);
    endtask

    task automatic t_priority;
        commit; #1 check("R10 commit leaves serial word", 12'h5A5);
        @(negedge ser_clk); #1 wipe_n = 1'b0; #0.5 check("R5 async clear", '0);
        @(negedge ser_clk); #1 commit_n = 1'b0; #0.5 check("R9 clear over commit", '0);
        @(negedge ser_clk); commit_n = 1'b1;
        @(negedge ser_clk); wipe_n = 1'b1; #1 check("R9 still zero after release", '0);
    endtask

    task automatic t_mid_clear;
        shift_bits(32'h2D, 6);
        @(negedge ser_clk); wipe_n = 1'b0;
        @(negedge ser_clk); #1 check("R5 mid-word clear", '0);
        wipe_n = 1'b1;
        shift_bits(32'h1E, 6); commit; #1 check("R10 word survives clear", 12'hB5E);
        shift_bits(32'h7, 4); commit; #1 check("R10 R6 rolling window", 12'h5E7);
    endtask

    initial begin
        t_reset();
        t_basic();
        t_scale();
        t_overrun();
        t_gated();
        t_hold();
        t_priority();
        t_mid_clear();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge ser_clk);
                n_cmp++; n_bad++;
                $display("FAIL watchdog: actual=timeout expected=completion");
            end
        join_any
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule